// File: doc/BRIEF.md
# Masked Time/Date Alarm Comparator

This block watches a running calendar time (day of month, hours, minutes and seconds, each in BCD) and raises a sticky alarm flag when that time equals a programmed alarm value. Each of the four alarm fields has its own active-low match-enable bit, so the alarm can be made to fire once per minute, once per hour, once per day or once per month. An optional interrupt output follows the flag while the interrupt-enable input is high. The timekeeping counters sit outside the block. They provide the current field values together with a one-cycle seconds tick.

Software programs the alarm through a small write port. A global write-enable level must be high for writes to land, and writes go into a staging copy of each field. The comparator keeps using the previously committed values until the write-enable level falls. At that point all four staged fields are copied into the active set together. A flags-read strobe clears the flag.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset the flag and interrupt are 0 and every match-enable bit is 1, so a seconds tick with any time does not raise the flag.
- R2: A write with `wr_en`=1 stores `wr_data` into the staging copy of the field chosen by `wr_sel` (0 seconds, 1 minutes, 2 hours, 3 date). Bit 7 of `wr_data` is the match-enable bit and bits 6:0 are the BCD value. The write only lands while `wen_bit`=1; a write made while `wen_bit`=0 changes nothing.
- R3: Staged values reach the comparator only in the cycle after `wen_bit` goes from 1 to 0. Until then, alarms are judged against the previously committed values.
- R4: For the minutes, hours and date fields, a committed match-enable bit of 0 puts the field in the comparison and a bit of 1 leaves it out.
- R5: When all four committed match-enable bits are 1, the flag is never raised.
- R6: Whenever the alarm is enabled (at least one match-enable bit is 0), the seconds field is always compared, whatever its own match-enable bit says.
- R7: The flag is set in the cycle after a cycle with `sec_tick`=1 in which every compared field equals the current value. An equal time without a tick does not set the flag.
- R8: `alarm_irq` is 1 exactly when the flag is 1 and `irq_enable` was 1 in the cycle that produced that flag value.
- R9: A cycle with `flags_rd`=1 clears the flag on the next cycle, unless a match is recorded in that same cycle, in which case the flag is set.
- R10: When there is neither a recorded match nor a flags read, the flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse when the seconds count advances |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 7 | Current hours, BCD |
| cur_date | input | 7 | Current day of month, BCD |
| wen_bit | input | 1 | Global write-enable level; its falling edge commits staged fields |
| wr_en | input | 1 | Write strobe for an alarm field |
| wr_sel | input | 2 | Field select: 0 sec, 1 min, 2 hour, 3 date |
| wr_data | input | 8 | Bit 7 match-enable (active low), bits 6:0 BCD value |
| irq_enable | input | 1 | Alarm interrupt enable |
| flags_rd | input | 1 | Flags-read strobe, clears the flag |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Alarm interrupt |

## Verification
The hardest case to reach is the window in which staged and committed alarm values differ. To get there, the bench holds `wen_bit` high after a write and sends seconds ticks matching the old value and the new value. It expects only the old value to fire until `wen_bit` drops. The bench also sweeps all sixteen match-enable patterns against all sixteen combinations of per-field equality, with expected results computed arithmetically. It places a match tick and a flags read in the same cycle to show that the set wins.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int unsigned NUM_FIELDS = 4;
  localparam int unsigned SEL_W      = $clog2(NUM_FIELDS);
  localparam int unsigned IDX_SEC    = 0;
  localparam int unsigned IDX_MIN    = 1;
  localparam int unsigned IDX_HOUR   = 2;
  localparam int unsigned IDX_DATE   = 3;
endpackage

// File: rtl/alarm_field_reg.sv
module alarm_field_reg #(
  parameter int unsigned FIELD_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_stb,
  input  logic               wr_mask,
  input  logic [FIELD_W-1:0] wr_val,
  input  logic               commit,
  output logic               act_mask,
  output logic [FIELD_W-1:0] act_val
);
  logic               stg_mask;
  logic [FIELD_W-1:0] stg_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_mask <= 1'b1;
      stg_val  <= '0;
    end else if (wr_stb) begin
      stg_mask <= wr_mask;
      stg_val  <= wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_mask <= 1'b1;
      act_val  <= '0;
    end else if (commit) begin
      act_mask <= stg_mask;
      act_val  <= stg_val;
    end
  end

  // R3: committed copy takes the staged value on commit, holds otherwise
  a_r3_commit_copies: assert property (@(posedge clk) disable iff (rst)
    commit |=> (act_val == $past(stg_val)) && (act_mask == $past(stg_mask)));
  a_r3_hold_without_commit: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(act_val) && $stable(act_mask));
endmodule

// File: rtl/alarm_compare.sv
module alarm_compare
  import alarm_pkg::*;
#(
  parameter int unsigned FIELD_W = 7
) (
  input  logic [NUM_FIELDS-1:0]              mask,
  input  logic [NUM_FIELDS-1:0][FIELD_W-1:0] alarm_val,
  input  logic [NUM_FIELDS-1:0][FIELD_W-1:0] now_val,
  output logic                               hit
);
  logic [NUM_FIELDS-1:0] field_ok;
  logic                  enabled;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    if (g == IDX_SEC) begin : g_always
      assign field_ok[g] = (alarm_val[g] == now_val[g]);
    end else begin : g_masked
      assign field_ok[g] = mask[g] | (alarm_val[g] == now_val[g]);
    end
  end

  assign enabled = ~&mask;
  assign hit     = enabled & (&field_ok);
endmodule

// File: rtl/alarm_flag_ctrl.sv
module alarm_flag_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic hit,
  input  logic rd,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  logic set_evt;
  logic flag_d;

  assign set_evt = tick & hit;

  always_comb begin
    flag_d = flag;
    if (rd)      flag_d = 1'b0;
    if (set_evt) flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      flag <= flag_d;
      irq  <= flag_d & irq_en;
    end
  end

  a_r7_set_on_match: assert property (@(posedge clk) disable iff (rst)
    (tick && hit) |=> flag);
  a_r7_no_set_without_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> !$rose(flag));
  a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd && !(tick && hit)) |=> !flag);
  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    (!rd && !(tick && hit)) |=> $stable(flag));
  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag);
  a_r8_irq_gated: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq);
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
  import alarm_pkg::*;
#(
  parameter int unsigned FIELD_W = 7,
  localparam int unsigned DATA_W = FIELD_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sec_tick,
  input  logic [FIELD_W-1:0] cur_sec,
  input  logic [FIELD_W-1:0] cur_min,
  input  logic [FIELD_W-1:0] cur_hour,
  input  logic [FIELD_W-1:0] cur_date,
  input  logic               wen_bit,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               irq_enable,
  input  logic               flags_rd,
  output logic               alarm_flag,
  output logic               alarm_irq
);
  logic                               wen_q;
  logic                               commit;
  logic [NUM_FIELDS-1:0]              act_mask;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] act_val;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] now_val;
  logic                               hit;

  always_ff @(posedge clk) begin
    if (rst) wen_q <= 1'b0;
    else     wen_q <= wen_bit;
  end

  assign commit = wen_q & ~wen_bit;

  assign now_val[IDX_SEC]  = cur_sec;
  assign now_val[IDX_MIN]  = cur_min;
  assign now_val[IDX_HOUR] = cur_hour;
  assign now_val[IDX_DATE] = cur_date;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_reg
    logic stb;
    assign stb = wr_en & wen_bit & (wr_sel == SEL_W'(g));
    alarm_field_reg #(.FIELD_W(FIELD_W)) u_field (
      .clk      (clk),
      .rst      (rst),
      .wr_stb   (stb),
      .wr_mask  (wr_data[DATA_W-1]),
      .wr_val   (wr_data[FIELD_W-1:0]),
      .commit   (commit),
      .act_mask (act_mask[g]),
      .act_val  (act_val[g])
    );
  end

  alarm_compare #(.FIELD_W(FIELD_W)) u_cmp (
    .mask      (act_mask),
    .alarm_val (act_val),
    .now_val   (now_val),
    .hit       (hit)
  );

  alarm_flag_ctrl u_flag (
    .clk    (clk),
    .rst    (rst),
    .tick   (sec_tick),
    .hit    (hit),
    .rd     (flags_rd),
    .irq_en (irq_enable),
    .flag   (alarm_flag),
    .irq    (alarm_irq)
  );

  // R5: every field left out means the comparator never reports a hit
  a_r5_disabled_no_hit: assert property (@(posedge clk) disable iff (rst)
    (&act_mask) |-> !hit);
  // R6: enabled alarm with a seconds mismatch never hits
  a_r6_seconds_checked: assert property (@(posedge clk) disable iff (rst)
    (act_val[IDX_SEC] != cur_sec) |-> !hit);
  // R2: committed values move only after a write-enable fall
  a_r2_no_change_while_open: assert property (@(posedge clk) disable iff (rst)
    wen_bit |=> $stable(act_val));
endmodule

// File: tb/alarm_match_unit_bench.sv
module alarm_match_unit_bench;
  localparam int FW = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sec_tick = 1'b0;
  logic [FW-1:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_date = '0;
  logic          wen_bit = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = '0;
  logic [FW:0]   wr_data = '0;
  logic          irq_enable = 1'b0;
  logic          flags_rd = 1'b0;
  logic          alarm_flag, alarm_irq;

  int checks = 0;
  int failures = 0;
  logic [FW-1:0] al [4];

  always #5 clk = ~clk;

  alarm_match_unit #(.FIELD_W(FW)) u_alarm_match_unit (
    .clk(clk), .rst(rst), .sec_tick(sec_tick),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_date(cur_date),
    .wen_bit(wen_bit), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .irq_enable(irq_enable), .flags_rd(flags_rd),
    .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic wr_field(input int sel, input logic msk, input logic [FW-1:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = {msk, v};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic open_w();
    @(negedge clk); wen_bit = 1'b1;
  endtask

  task automatic close_w();
    @(negedge clk); wen_bit = 1'b0;
    @(negedge clk);
  endtask

  task automatic program_all(input logic [3:0] m, input logic [FW-1:0] s);
    open_w();
    wr_field(0, m[0], s);
    wr_field(1, m[1], al[1]);
    wr_field(2, m[2], al[2]);
    wr_field(3, m[3], al[3]);
    close_w();
  endtask

  task automatic set_time(input logic [FW-1:0] s, m, h, d);
    cur_sec = s; cur_min = m; cur_hour = h; cur_date = d;
  endtask

  // one cycle with a tick (and optional read); outputs sampled after the edge
  task automatic tick(input logic [FW-1:0] s, m, h, d, input logic rd);
    @(negedge clk);
    set_time(s, m, h, d);
    sec_tick = 1'b1; flags_rd = rd;
    @(negedge clk);
    sec_tick = 1'b0; flags_rd = 1'b0;
  endtask

  task automatic read_flags();
    @(negedge clk); flags_rd = 1'b1;
    @(negedge clk); flags_rd = 1'b0;
  endtask

  initial begin
    al[0] = 7'h45; al[1] = 7'h30; al[2] = 7'h08; al[3] = 7'h15;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 flag after reset", alarm_flag, 1'b0);
    chk("R1 irq after reset", alarm_irq, 1'b0);
    irq_enable = 1'b1;
    tick(7'h00, 7'h00, 7'h00, 7'h00, 1'b0);
    chk("R1 default masks disable alarm", alarm_flag, 1'b0);

    // sweep: all mask patterns x all per-field equality patterns (R4 R5 R6 R8)
    for (int m = 0; m < 16; m++) begin
      program_all(4'(m), al[0]);
      irq_enable = m[0] ^ m[2];
      for (int p = 0; p < 16; p++) begin
        logic [FW-1:0] tv [4];
        logic exp;
        for (int f = 0; f < 4; f++) tv[f] = p[f] ? al[f] : (al[f] ^ 7'h01);
        read_flags();
        tick(tv[0], tv[1], tv[2], tv[3], 1'b0);
        exp = (m != 15) && p[0] && (m[1] || p[1]) && (m[2] || p[2]) && (m[3] || p[3]);
        chk(m == 15 ? "R5 disabled" : "R4 R6 masked compare", alarm_flag, exp);
        chk("R8 irq gating", alarm_irq, exp & (m[0] ^ m[2]));
      end
    end

    // R7: equal time without a tick does not set the flag
    irq_enable = 1'b1;
    program_all(4'h0, al[0]);
    read_flags();
    @(negedge clk);
    set_time(al[0], al[1], al[2], al[3]);
    repeat (3) @(negedge clk);
    chk("R7 no tick no flag", alarm_flag, 1'b0);
    tick(al[0], al[1], al[2], al[3], 1'b0);
    chk("R7 tick sets flag", alarm_flag, 1'b1);

    // R10: sticky across a non-matching tick
    tick(7'h00, al[1], al[2], al[3], 1'b0);
    chk("R10 flag holds", alarm_flag, 1'b1);
    // R9: read clears, set wins over simultaneous read
    read_flags();
    chk("R9 read clears", alarm_flag, 1'b0);
    chk("R9 read clears irq", alarm_irq, 1'b0);
    tick(al[0], al[1], al[2], al[3], 1'b1);
    chk("R9 set beats read", alarm_flag, 1'b1);
    read_flags();

    // R3: staged value not used until write-enable falls
    open_w();
    wr_field(0, 1'b0, 7'h12);
    tick(al[0], al[1], al[2], al[3], 1'b0);
    chk("R3 old value still active", alarm_flag, 1'b1);
    read_flags();
    tick(7'h12, al[1], al[2], al[3], 1'b0);
    chk("R3 staged value not active", alarm_flag, 1'b0);
    close_w();
    tick(7'h12, al[1], al[2], al[3], 1'b0);
    chk("R3 committed value active", alarm_flag, 1'b1);
    read_flags();

    // R2: write while write-enable is low is ignored
    wr_field(0, 1'b0, 7'h33);
    open_w();
    close_w();
    tick(7'h33, al[1], al[2], al[3], 1'b0);
    chk("R2 closed write ignored (new value)", alarm_flag, 1'b0);
    tick(7'h12, al[1], al[2], al[3], 1'b0);
    chk("R2 closed write ignored (old value)", alarm_flag, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule